// File: doc/BRIEF.md
# Prefetching Byte-Bus Interface Unit

This block is the bus side of a small CPU with an 8-bit data bus. It runs on its own, apart from the execution side. It keeps a four-byte instruction queue filled ahead of use. Each byte comes from a four-state bus transfer, and every completed fetch moves the prefetch pointer on by one byte. The execution side takes bytes from the head of the queue with a pop strobe.

The execution side can also ask for a data read or write, as a single byte or as a 16-bit word. Such a request is served before any further prefetch. A word is moved as two byte transfers, low byte first, and completion is marked by a one-cycle done pulse. A control transfer sends a redirect carrying a new segment and offset. This empties the queue and restarts fetching at the new physical address. A ready input lets slow devices stretch any transfer with wait states.

Top module: `fetch_bus_unit`

## Requirements
- R1: The queue holds at most four bytes. Bytes leave in the order they arrived. `q_valid_o` is high exactly when the queue holds at least one byte, and `q_byte_o` then shows the oldest byte.
- R2: A transfer without wait states lasts four cycles, T1 to T4. `bus_ale_o` is high only in T1. Exactly one of `bus_rd_o` and `bus_wr_o` is high through the whole transfer, and `bus_addr_o` holds still from T1 to T4.
- R3: While reset is held, the queue is empty, no strobe is active and `done_o` is low. The first transfer after reset is a fetch from 0xFFFF0, and its T1 falls in the first cycle after reset is released.
- R4: The prefetch address goes up by one after each fetch that completes. A fetch is started only if a queue slot stays free once the in-flight fetch is counted. With the queue full, the bus stays idle with both strobes low. With a slot free, an idle bus starts a fetch on the next cycle.
- R5: A physical address is (segment × 16 + offset) modulo 2^20. For example, F000:E05B gives 0xFE05B and FFFF:FFFF gives 0x0FFEF.
- R6: A redirect empties the queue by the next cycle. A pop in the same cycle as the redirect is ignored. A fetch already on the bus runs to its T4, but its byte is dropped. The next fetch uses the redirect target.
- R7: A pending data request waits for the current transfer's T4 and is started ahead of any prefetch. A word access uses address A and then A+1 back to back, low byte first, with `bus_wdata_o` carrying the matching byte of a write. `done_o` pulses for one cycle, the cycle after the last T4. For a read, `rdata_o` then holds {byte at A+1, byte at A}; a byte read has zero in the upper half. The requester drops `dreq_i` in the cycle where it sees `done_o` high.
- R8: A pop and a push from a completing fetch in the same cycle both take effect, so no byte is lost or repeated.
- R9: While `bus_ready_i` is low at the end of T3, the unit stays in T3 and the strobe stays active. T4 follows the first T3 cycle that ends with ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_o | output | 20 | Physical address of the current transfer |
| bus_wdata_o | output | 8 | Write byte |
| bus_rdata_i | input | 8 | Read byte, sampled in T4 |
| bus_ale_o | output | 1 | Address strobe, high in T1 |
| bus_rd_o | output | 1 | Read transfer active |
| bus_wr_o | output | 1 | Write transfer active |
| bus_ready_i | input | 1 | Low inserts wait states after T3 |
| q_byte_o | output | 8 | Oldest queued instruction byte |
| q_valid_o | output | 1 | Queue not empty |
| q_pop_i | input | 1 | Remove the head byte |
| dreq_i | input | 1 | Data access request, held until done |
| dreq_we_i | input | 1 | 1 = write, 0 = read |
| dreq_word_i | input | 1 | 1 = 16-bit access, 0 = byte |
| dreq_seg_i | input | 16 | Data segment |
| dreq_off_i | input | 16 | Data offset |
| dreq_wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, valid with done |
| redir_i | input | 1 | Flush and restart fetching |
| redir_seg_i | input | 16 | Target segment |
| redir_off_i | input | 16 | Target offset |

## Verification
Two things can happen in the same clock: a fetch completes and pushes a byte, and the execution side pops the head. The bench provokes this by first letting the queue fill. It then pops on every other cycle, which drains faster than the four-cycle fetch refills, so pops land on fetch T4 edges again and again. Each popped byte is compared against the memory pattern at a steadily rising address, so a byte that is lost or repeated at a shared edge breaks the sequence. A redirect arriving during T2 of a fetch is a second overlap. It is judged by the address of the next T1 and by the first byte that comes out of the queue.

// File: rtl/fetch_bus_pkg.sv
package fetch_bus_pkg;
  typedef enum logic [2:0] {
    BS_IDLE,
    BS_T1,
    BS_T2,
    BS_T3,
    BS_T4
  } bus_state_e;

  typedef enum logic [1:0] {
    XK_FETCH,
    XK_DRD,
    XK_DWR
  } xfer_kind_e;
endpackage

// File: rtl/fetch_queue.sv
module fetch_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          valid_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign do_pop = pop_i && (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop) rd_ptr <= ptr_inc(rd_ptr);
      cnt <= cnt + CW'(push_i) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem[wr_ptr] <= din_i;
  end

  assign head_o  = mem[rd_ptr];
  assign valid_o = (cnt != '0);
  assign count_o = cnt;
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import fetch_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       ready_i,
  output bus_state_e state_o,
  output logic       decide_o
);
  bus_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      BS_IDLE: state_d = start_i ? BS_T1 : BS_IDLE;
      BS_T1:   state_d = BS_T2;
      BS_T2:   state_d = BS_T3;
      BS_T3:   state_d = ready_i ? BS_T4 : BS_T3;
      BS_T4:   state_d = start_i ? BS_T1 : BS_IDLE;
      default: state_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= BS_IDLE;
    else         state_o <= state_d;
  end

  // next transfer is chosen only when nothing else is in flight
  assign decide_o = (state_o == BS_IDLE) || (state_o == BS_T4);
endmodule

// File: rtl/fetch_bus_unit.sv
module fetch_bus_unit
  import fetch_bus_pkg::*;
#(
  parameter int unsigned    DEPTH    = 4,
  parameter int unsigned    DW       = 8,
  parameter int unsigned    SEG_W    = 16,
  parameter int unsigned    PA_W     = 20,
  parameter logic [PA_W-1:0] RESET_PA = 20'hFFFF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PA_W-1:0]   bus_addr_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic [DW-1:0]     bus_rdata_i,
  output logic              bus_ale_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  input  logic              bus_ready_i,
  output logic [DW-1:0]     q_byte_o,
  output logic              q_valid_o,
  input  logic              q_pop_i,
  input  logic              dreq_i,
  input  logic              dreq_we_i,
  input  logic              dreq_word_i,
  input  logic [SEG_W-1:0]  dreq_seg_i,
  input  logic [SEG_W-1:0]  dreq_off_i,
  input  logic [2*DW-1:0]   dreq_wdata_i,
  output logic              done_o,
  output logic [2*DW-1:0]   rdata_o,
  input  logic              redir_i,
  input  logic [SEG_W-1:0]  redir_seg_i,
  input  logic [SEG_W-1:0]  redir_off_i
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned SH = PA_W - SEG_W;

  function automatic logic [PA_W-1:0] phys(input logic [SEG_W-1:0] s, input logic [SEG_W-1:0] o);
    return {s, {SH{1'b0}}} + {{SH{1'b0}}, o};
  endfunction

  bus_state_e       bus_state;
  logic             decide;
  logic             start;
  logic [CW-1:0]    q_count;
  logic [CW:0]      cnt_next;

  xfer_kind_e       kind_q, kind_d;
  logic [PA_W-1:0]  addr_q, addr_d;
  logic [DW-1:0]    wbyte_q, wbyte_d;
  logic [PA_W-1:0]  pf_addr, pf_next;
  logic             discard_q;
  logic             dphase_q, dphase_d;
  logic [DW-1:0]    dlow_q;
  logic             done_q;
  logic [2*DW-1:0]  rdata_q;

  logic busy, at_t4, fetch_cmpl, data_first, data_last;
  logic push, pop, data_want, fetch_want;

  assign busy       = (bus_state != BS_IDLE);
  assign at_t4      = (bus_state == BS_T4);
  assign fetch_cmpl = at_t4 && (kind_q == XK_FETCH);
  assign data_first = at_t4 && (kind_q != XK_FETCH) && dreq_word_i && !dphase_q;
  assign data_last  = at_t4 && (kind_q != XK_FETCH) && !(dreq_word_i && !dphase_q);

  // redirect wins over a same-cycle pop and over a completing fetch
  assign push = fetch_cmpl && !discard_q && !redir_i;
  assign pop  = q_pop_i && q_valid_o && !redir_i;

  assign cnt_next = redir_i ? '0
                  : ({1'b0, q_count} + (CW+1)'(push) - (CW+1)'(pop));

  assign pf_next = redir_i ? phys(redir_seg_i, redir_off_i)
                 : ((fetch_cmpl && !discard_q) ? pf_addr + PA_W'(1) : pf_addr);

  // done cycle blocks a re-grant while the requester drops its strobe
  assign data_want  = dreq_i && !done_q && !data_last;
  assign fetch_want = (cnt_next < (CW+1)'(DEPTH));
  assign start      = decide && (data_want || fetch_want);

  assign dphase_d = data_first ? 1'b1 : (data_last ? 1'b0 : dphase_q);

  always_comb begin
    if (data_want) begin
      kind_d  = dreq_we_i ? XK_DWR : XK_DRD;
      addr_d  = phys(dreq_seg_i, dreq_off_i) + PA_W'(dphase_d);
      wbyte_d = dphase_d ? dreq_wdata_i[2*DW-1:DW] : dreq_wdata_i[DW-1:0];
    end else begin
      kind_d  = XK_FETCH;
      addr_d  = pf_next;
      wbyte_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q    <= XK_FETCH;
      addr_q    <= '0;
      wbyte_q   <= '0;
      pf_addr   <= RESET_PA;
      discard_q <= 1'b0;
      dphase_q  <= 1'b0;
      dlow_q    <= '0;
      done_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      pf_addr  <= pf_next;
      done_q   <= data_last;
      dphase_q <= dphase_d;
      if (start) begin
        kind_q  <= kind_d;
        addr_q  <= addr_d;
        wbyte_q <= wbyte_d;
      end
      if (redir_i && busy && (kind_q == XK_FETCH) && !at_t4) discard_q <= 1'b1;
      else if (at_t4)                                         discard_q <= 1'b0;
      if (data_first) dlow_q <= bus_rdata_i;
      if (data_last && (kind_q == XK_DRD))
        rdata_q <= dphase_q ? {bus_rdata_i, dlow_q} : {{DW{1'b0}}, bus_rdata_i};
    end
  end

  bus_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ready_i (bus_ready_i),
    .state_o (bus_state),
    .decide_o(decide)
  );

  fetch_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(redir_i),
    .push_i (push),
    .din_i  (bus_rdata_i),
    .pop_i  (pop),
    .head_o (q_byte_o),
    .valid_o(q_valid_o),
    .count_o(q_count)
  );

  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wbyte_q;
  assign bus_ale_o   = (bus_state == BS_T1);
  assign bus_rd_o    = busy && (kind_q != XK_DWR);
  assign bus_wr_o    = busy && (kind_q == XK_DWR);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/fetch_bus_chk.sv
module fetch_bus_chk
  import fetch_bus_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PA_W  = 20,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input bus_state_e      state_i,
  input logic [CW-1:0]   q_count_i,
  input logic            q_valid_i,
  input logic            ale_i,
  input logic            rd_i,
  input logic            wr_i,
  input logic [PA_W-1:0] addr_i,
  input logic            ready_i,
  input logic            redir_i,
  input logic            done_i
);
  p_depth_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count_i <= CW'(DEPTH));

  p_ale_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |=> !ale_i);

  p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |-> (rd_i ^ wr_i));

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && !ale_i) |-> $stable(addr_i));

  p_idle_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == BS_IDLE && q_count_i < CW'(DEPTH)) |=> (state_i == BS_T1));

  p_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> !q_valid_i);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_wait_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == BS_T3 && !ready_i) |=> (state_i == BS_T3 && (rd_i || wr_i)));
endmodule

bind fetch_bus_unit fetch_bus_chk #(.DEPTH(DEPTH), .PA_W(PA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .state_i  (bus_state),
  .q_count_i(q_count),
  .q_valid_i(q_valid_o),
  .ale_i    (bus_ale_o),
  .rd_i     (bus_rd_o),
  .wr_i     (bus_wr_o),
  .addr_i   (bus_addr_o),
  .ready_i  (bus_ready_i),
  .redir_i  (redir_i),
  .done_i   (done_o)
);

// File: tb/fetch_bus_unit_tb_top.sv
`timescale 1ns/1ps
module fetch_bus_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_ale, bus_rd, bus_wr;
  logic        ready = 1'b1;
  logic [7:0]  q_byte;
  logic        q_valid;
  logic        q_pop = 1'b0;
  logic        dreq = 1'b0, dwe = 1'b0, dword = 1'b0;
  logic [15:0] dseg = '0, doff = '0, dwdata = '0;
  logic        done;
  logic [15:0] rdata;
  logic        redir = 1'b0;
  logic [15:0] rseg = '0, roff = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]};
  endfunction

  assign bus_rdata = mb(bus_addr);

  fetch_bus_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_ale_o(bus_ale), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_ready_i(ready),
    .q_byte_o(q_byte), .q_valid_o(q_valid), .q_pop_i(q_pop),
    .dreq_i(dreq), .dreq_we_i(dwe), .dreq_word_i(dword),
    .dreq_seg_i(dseg), .dreq_off_i(doff), .dreq_wdata_i(dwdata),
    .done_o(done), .rdata_o(rdata),
    .redir_i(redir), .redir_seg_i(rseg), .redir_off_i(roff)
  );

  typedef struct packed {
    logic [15:0] s;
    logic [15:0] o;
    logic [19:0] pa;
  } rvec_t;

  localparam rvec_t RTAB [4] = '{
    '{16'hF000, 16'hE05B, 20'hFE05B},
    '{16'h0040, 16'h0472, 20'h00872},
    '{16'hFFFF, 16'hFFFF, 20'h0FFEF},
    '{16'h1234, 16'h5678, 20'h179B8}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic next_ale(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_ale && n < 64);
    if (!bus_ale) chk("R2", "ale seen", 32'd0, 32'd1);
  endtask

  task automatic redirect(input logic [15:0] s, input logic [15:0] o);
    rseg = s; roff = o; redir = 1'b1;
    @(negedge clk);
    redir = 1'b0;
  endtask

  task automatic pop_chk(input logic [19:0] a, input string req);
    int w = 0;
    while (!q_valid && w < 64) begin @(negedge clk); w++; end
    chk(req, "queue byte", {24'd0, q_byte}, {24'd0, mb(a)});
    q_pop = 1'b1;
    @(negedge clk);
    q_pop = 1'b0;
  endtask

  task automatic data_op(input bit we, input bit word, input logic [15:0] s, input logic [15:0] o,
                         input logic [15:0] wd);
    logic [19:0] pa;
    int n;
    pa = {s, 4'h0} + {4'h0, o};
    dwe = we; dword = word; dseg = s; doff = o; dwdata = wd; dreq = 1'b1;
    next_ale(n);
    chk("R7", "data addr lo", {12'd0, bus_addr}, {12'd0, pa});
    chk("R7", "data dir", {30'd0, bus_rd, bus_wr}, we ? 32'd1 : 32'd2);
    if (we) chk("R7", "wdata lo", {24'd0, bus_wdata}, {24'd0, wd[7:0]});
    if (word) begin
      next_ale(n);
      chk("R7", "word gap", n, 4);
      chk("R7", "data addr hi", {12'd0, bus_addr}, {12'd0, pa + 20'd1});
      if (we) chk("R7", "wdata hi", {24'd0, bus_wdata}, {24'd0, wd[15:8]});
    end
    n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 20);
    chk("R7", "done timing", n, 4);
    if (!we)
      chk("R7", "rdata", {16'd0, rdata},
          word ? {16'd0, mb(pa + 20'd1), mb(pa)} : {24'd0, mb(pa)});
    dreq = 1'b0;
    @(negedge clk);
    chk("R7", "done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    logic [19:0] exp_a;
    repeat (3) @(negedge clk);
    chk("R3", "reset valid", {31'd0, q_valid}, 32'd0);
    chk("R3", "reset strobes", {30'd0, bus_rd, bus_wr}, 32'd0);
    chk("R3", "reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;

    next_ale(n);
    chk("R3", "first fetch cycle", n, 1);
    chk("R3", "first fetch addr", {12'd0, bus_addr}, 32'hFFFF0);
    chk("R2", "read strobe", {31'd0, bus_rd}, 32'd1);
    next_ale(n);
    chk("R2", "transfer length", n, 4);
    chk("R4", "address step", {12'd0, bus_addr}, 32'hFFFF1);

    repeat (30) @(negedge clk);
    chk("R4", "idle when full", {29'd0, bus_rd, bus_wr, bus_ale}, 32'd0);
    q_pop = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R1", "fifo order", {24'd0, q_byte}, {24'd0, mb(20'hFFFF0 + 20'(i))});
      @(negedge clk);
    end
    q_pop = 1'b0;

    // refill, then drain at half rate so pops meet fetch T4 edges (R8)
    repeat (20) @(negedge clk);
    exp_a = 20'hFFFF4;
    for (int c = 0; c < 40; c++) begin
      if (c % 2 == 0 && q_valid) begin
        chk("R8", "push/pop stream", {24'd0, q_byte}, {24'd0, mb(exp_a)});
        exp_a = exp_a + 20'd1;
        q_pop = 1'b1;
      end else begin
        q_pop = 1'b0;
      end
      @(negedge clk);
    end
    q_pop = 1'b0;

    foreach (RTAB[k]) begin
      q_pop = 1'b1;
      redirect(RTAB[k].s, RTAB[k].o);
      q_pop = 1'b0;
      chk("R6", "flush", {31'd0, q_valid}, 32'd0);
      for (int i = 0; i < 3; i++) pop_chk(RTAB[k].pa + 20'(i), "R5");
    end

    // redirect during T2 of a fetch
    redirect(16'h2000, 16'h0000);
    next_ale(n);
    chk("R6", "target fetch", {12'd0, bus_addr}, 32'h20000);
    @(negedge clk);
    redirect(16'h3000, 16'h0100);
    next_ale(n);
    chk("R6", "old fetch finishes", n, 2);
    chk("R6", "new target addr", {12'd0, bus_addr}, 32'h30100);
    chk("R6", "stale byte dropped", {31'd0, q_valid}, 32'd0);
    pop_chk(20'h30100, "R6");

    // wait states
    redirect(16'h4000, 16'h0000);
    next_ale(n);
    @(negedge clk);
    ready = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "strobe held", {30'd0, bus_rd, bus_ale}, 32'd2);
    @(negedge clk);
    ready = 1'b1;
    next_ale(n);
    chk("R9", "stretched length", n + 4, 6);
    pop_chk(20'h40000, "R9");

    // data accesses beat pending prefetch
    redirect(16'h5000, 16'h0000);
    data_op(1'b0, 1'b1, 16'h0040, 16'h0472, 16'h0000);
    data_op(1'b0, 1'b0, 16'h1234, 16'h0001, 16'h0000);
    data_op(1'b1, 1'b0, 16'h1000, 16'h0010, 16'h00A5);
    redirect(16'h6000, 16'h0000);
    data_op(1'b1, 1'b1, 16'hF000, 16'hFFFF, 16'hBEEF);
    pop_chk(20'h60000, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule